// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between a processor's register bus and the byte-wide serial engine of an SPI master. It keeps two byte FIFOs: one that software fills with 32-bit writes and the shifter drains a byte at a time, and one that the shifter fills a byte at a time and software drains with 32-bit reads. It reports both FIFO occupancies live in a status word. Two sticky threshold flags, "receive has data" and "transmit has room", sit in the same word. They are cleared by writing ones and are gated by a mask into one level interrupt.

Software programs two 6-bit thresholds in a settings word and enables the flags it cares about in the mask. It then services the interrupt by moving data through the two port addresses and clearing flags. The serial side uses valid/ready byte streams. The transmit stream presents a byte while the transmit FIFO holds one, and the byte leaves when `tx_ready` is high in that cycle. The receive stream is accepted only while the receive FIFO has room, so the serial engine must hold `rx_valid` and `rx_data` until `rx_ready` is seen. Serial shifting, chip select and clock generation live outside this block.

Bus accesses take effect at the clock edge where `bus_en` is high. Read data appears on `bus_rdata` from that edge onward and stays there until the next read.

Top module: `spi_fifo_event_unit`

## Requirements
- R1: After reset the settings word reads 0x0000_0403 (transmit threshold 4, receive threshold 3), the mask reads 0, both FIFOs are empty, `irq` is low and the status word reads 0x0000_0100 once the flags have updated.
- R2: Byte addresses are 0x00 settings, 0x04 status, 0x08 mask, 0x10 transmit port and 0x14 receive port. In the settings word, bits 13:8 hold the transmit threshold and bits 5:0 the receive threshold. The mask stores only bits 9 and 8. Other bits of both registers read 0.
- R3: Status bits 29:24 give the receive FIFO byte count and bits 21:16 the transmit FIFO byte count, each 6 bits wide and live.
- R4: Status bit 9 (receive has data) sets when the receive byte count is strictly greater than the receive threshold.
- R5: Status bit 8 (transmit has room) sets when the free transmit space (32 minus the count) is strictly greater than the transmit threshold.
- R6: Writing the status word clears each flag whose bit is 1 in the written value. If a flag's set condition still holds, setting wins and the flag stays 1.
- R7: The count fields of the status word are read-only, and writes to them leave the counts unchanged.
- R8: `irq` is high exactly while some status flag and its mask bit are both 1.
- R9: A transmit port write pushes four bytes, bits 31:24 first and bits 7:0 last. The transmit stream emits them in that order, one per cycle with `tx_valid` and `tx_ready` both high.
- R10: A receive port read pops min(4, count) bytes. The oldest byte is placed in bits 31:24, the next ones fill downward, and lanes with no byte read as 0.
- R11: Each FIFO holds 32 bytes. Transmit bytes that do not fit are dropped. `rx_ready` is low while the receive FIFO is full, so no byte enters it.
- R12: A receive stream byte accepted in the same cycle as a receive port read is kept. The count becomes old + 1 - popped, and the new byte follows the remaining ones in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_ready | input | 1 | Serial engine takes the byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Serial engine offers a byte |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |

## Verification
The receive FIFO can be filled from the serial stream and drained by a port read in the same clock cycle. The bench provokes this by raising `rx_valid` with a sixth byte on the exact edge where a read of the receive port hits a FIFO holding five bytes. It then judges the popped word, the count of two reported in the status word, and the order of the two bytes returned by the following read. A second collision occurs when a flag is cleared while its set condition still holds. A write-one-to-clear is issued under that condition, and the check is that the flag and the interrupt stay high.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int THR_W  = 6;

  localparam logic [ADDR_W-1:0] ADR_SETUP = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 6'h08;
  localparam logic [ADDR_W-1:0] ADR_TXP   = 6'h10;
  localparam logic [ADDR_W-1:0] ADR_RXP   = 6'h14;

  localparam int POS_RXHAS  = 9;
  localparam int POS_TXROOM = 8;
  localparam int POS_RXCNT  = 24;
  localparam int POS_TXCNT  = 16;
  localparam int POS_TXTHR  = 8;
  localparam int POS_RXTHR  = 0;

  localparam logic [THR_W-1:0] TXTHR_RST = 6'd4;
  localparam logic [THR_W-1:0] RXTHR_RST = 6'd3;

  typedef struct packed {
    logic rx_has;
    logic tx_room;
  } flag_t;
endpackage

// File: rtl/spi_evt_byte_fifo.sv
module spi_evt_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int CNT_W = 6,
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LW-1:0]      push_req,
  input  logic [LANES*8-1:0] push_data,
  input  logic [LW-1:0]      pop_req,
  output logic [LANES*8-1:0] peek_data,
  output logic [LW-1:0]      push_acc,
  output logic [LW-1:0]      pop_acc,
  output logic [CNT_W-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] free_sp, push_ext, pop_ext, push_n, pop_n;

  always_comb begin
    free_sp  = DEPTH_C - count;
    push_ext = CNT_W'(push_req);
    pop_ext  = CNT_W'(pop_req);
    push_n   = (push_ext > free_sp) ? free_sp : push_ext;
    pop_n    = (pop_ext > count) ? count : pop_ext;
    push_acc = LW'(push_n);
    pop_acc  = LW'(pop_n);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    assign peek_data[8*k +: 8] = mem[rd_ptr + PTR_W'(k)];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (CNT_W'(k) < push_n) mem[wr_ptr + PTR_W'(k)] <= push_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      count  <= count + push_n - pop_n;
    end
  end

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  // R11
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == DEPTH_C && pop_req == '0) |=> count == DEPTH_C);

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && push_req == '0) |=> count == '0);
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
  import spi_evt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_thr,
  input  logic             clr_we,
  input  flag_t            clr_bits,
  input  flag_t            mask,
  output flag_t            flags,
  output logic             irq
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  flag_t cond, clr_eff;

  always_comb begin
    cond.rx_has  = rx_cnt > CNT_W'(rx_thr);
    cond.tx_room = (DEPTH_C - tx_cnt) > CNT_W'(tx_thr);
    clr_eff      = clr_we ? clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= cond | (flags & ~clr_eff);
  end

  assign irq = |(flags & mask);

  // R4
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond.rx_has |=> flags.rx_has);

  // R5
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond.tx_room |=> flags.tx_room);

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits.rx_has && !cond.rx_has) |=> !flags.rx_has);

  // R6
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits.tx_room && !cond.tx_room) |=> !flags.tx_room);
endmodule

// File: rtl/spi_evt_regs.sv
module spi_evt_regs
  import spi_evt_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  flag_t              flags,
  input  logic [CNT_W-1:0]   rx_cnt,
  input  logic [CNT_W-1:0]   tx_cnt,
  input  logic [LANES*8-1:0] rx_peek,
  input  logic [LW-1:0]      rx_popped,
  output logic [THR_W-1:0]   tx_thr,
  output logic [THR_W-1:0]   rx_thr,
  output flag_t              mask,
  output logic [LW-1:0]      tx_push_req,
  output logic [LANES*8-1:0] tx_push_data,
  output logic [LW-1:0]      rx_pop_req,
  output logic               clr_we,
  output flag_t              clr_bits
);
  logic wr_hit, rd_hit;
  logic [DATA_W-1:0] rx_word, stat_word, rd_mux;

  assign wr_hit = bus_en && bus_wr;
  assign rd_hit = bus_en && !bus_wr;

  // Lane 0 of the FIFO is the oldest byte and maps to the top of the word.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign tx_push_data[8*k +: 8] = bus_wdata[DATA_W-1-8*k -: 8];
    assign rx_word[DATA_W-1-8*k -: 8] =
      (LW'(k) < rx_popped) ? rx_peek[8*k +: 8] : 8'h00;
  end

  always_comb begin
    tx_push_req = (wr_hit && bus_addr == ADR_TXP) ? LW'(LANES) : '0;
    rx_pop_req  = (rd_hit && bus_addr == ADR_RXP) ? LW'(LANES) : '0;
    clr_we      = wr_hit && bus_addr == ADR_STAT;
    clr_bits.rx_has  = bus_wdata[POS_RXHAS];
    clr_bits.tx_room = bus_wdata[POS_TXROOM];
  end

  always_comb begin
    stat_word = '0;
    stat_word[POS_RXCNT +: CNT_W] = rx_cnt;
    stat_word[POS_TXCNT +: CNT_W] = tx_cnt;
    stat_word[POS_RXHAS]  = flags.rx_has;
    stat_word[POS_TXROOM] = flags.tx_room;
    rd_mux = '0;
    case (bus_addr)
      ADR_SETUP: begin
        rd_mux[POS_TXTHR +: THR_W] = tx_thr;
        rd_mux[POS_RXTHR +: THR_W] = rx_thr;
      end
      ADR_STAT: rd_mux = stat_word;
      ADR_MASK: begin
        rd_mux[POS_RXHAS]  = mask.rx_has;
        rd_mux[POS_TXROOM] = mask.tx_room;
      end
      ADR_RXP:  rd_mux = rx_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr    <= TXTHR_RST;
      rx_thr    <= RXTHR_RST;
      mask      <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_hit && bus_addr == ADR_SETUP) begin
        tx_thr <= bus_wdata[POS_TXTHR +: THR_W];
        rx_thr <= bus_wdata[POS_RXTHR +: THR_W];
      end
      if (wr_hit && bus_addr == ADR_MASK) begin
        mask.rx_has  <= bus_wdata[POS_RXHAS];
        mask.tx_room <= bus_wdata[POS_TXROOM];
      end
      if (rd_hit) bus_rdata <= rd_mux;
    end
  end

  // R10
  rx_pop_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_popped <= LW'(LANES));
endmodule

// File: rtl/spi_fifo_event_unit.sv
module spi_fifo_event_unit
  import spi_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              irq
);
  localparam int LW = $clog2(LANES + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0]   tx_cnt, rx_cnt;
  logic [THR_W-1:0]   tx_thr, rx_thr;
  logic [LW-1:0]      tx_push_req, tx_pop_req, rx_push_req, rx_pop_req;
  logic [LW-1:0]      rx_popped, tx_unused_push, tx_unused_pop, rx_unused_push;
  logic [LANES*8-1:0] tx_push_data, tx_peek, rx_push_data, rx_peek;
  logic               clr_we;
  flag_t              clr_bits, mask, flags;
  logic [LANES*8-9:0] tx_unused_lanes;

  assign tx_valid        = tx_cnt != '0;
  assign rx_ready        = rx_cnt != DEPTH_C;
  assign tx_pop_req      = LW'(tx_valid && tx_ready);
  assign rx_push_req     = LW'(rx_valid && rx_ready);
  assign rx_push_data    = {{(LANES*8-8){1'b0}}, rx_data};
  assign tx_data         = tx_peek[7:0];
  assign tx_unused_lanes = tx_peek[LANES*8-1:8];

  spi_evt_regs #(.LANES(LANES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flags(flags), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_peek(rx_peek), .rx_popped(rx_popped),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask),
    .tx_push_req(tx_push_req), .tx_push_data(tx_push_data),
    .rx_pop_req(rx_pop_req), .clr_we(clr_we), .clr_bits(clr_bits)
  );

  spi_evt_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_req(tx_push_req), .push_data(tx_push_data),
    .pop_req(tx_pop_req), .peek_data(tx_peek),
    .push_acc(tx_unused_push), .pop_acc(tx_unused_pop), .count(tx_cnt)
  );

  spi_evt_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_req(rx_push_req), .push_data(rx_push_data),
    .pop_req(rx_pop_req), .peek_data(rx_peek),
    .push_acc(rx_unused_push), .pop_acc(rx_popped), .count(rx_cnt)
  );

  spi_evt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_thr(rx_thr), .tx_thr(tx_thr),
    .clr_we(clr_we), .clr_bits(clr_bits), .mask(mask),
    .flags(flags), .irq(irq)
  );

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(bus_en && bus_wr)) |=> (tx_valid && $stable(tx_data)));

  // R11
  rx_full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !(bus_en && !bus_wr && bus_addr == ADR_RXP)) |=> !rx_ready);
endmodule

// File: tb/tb_spi_fifo_event_unit.sv
module tb_spi_fifo_event_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  spi_fifo_event_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    idle(1);
  endtask

  task automatic tx_take(output logic [7:0] b, output logic v);
    @(negedge clk);
    v = tx_valid; b = tx_data; tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 settings after reset", 6'h00, 32'h0000_0403);
    rd_chk("R1 mask after reset", 6'h08, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
    check("R1 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
    rd_chk("R1 status after reset", 6'h04, 32'h0000_0100);
  endtask

  task automatic t_regs;
    wr(6'h08, 32'hFFFF_FFFF);
    rd_chk("R2 mask keeps bits 9:8", 6'h08, 32'h0000_0300);
    wr(6'h08, 32'h0);
    wr(6'h00, 32'hFFFF_FFFF);
    rd_chk("R2 settings keeps thresholds", 6'h00, 32'h0000_3F3F);
    rd_chk("R2 unmapped reads 0", 6'h18, 32'h0);
    wr(6'h00, 32'h0000_2003);
    wr(6'h04, 32'h0000_0100);
    rd_chk("R5 no room at threshold 32", 6'h04, 32'h0);
    wr(6'h00, 32'h0000_0403);
    idle(1);
    rd_chk("R5 room returns", 6'h04, 32'h0000_0100);
  endtask

  task automatic t_tx_basic;
    logic [7:0] b; logic v;
    wr(6'h10, 32'h1122_3344);
    idle(1);
    rd_chk("R3 tx count 4", 6'h04, 32'h0004_0100);
    check("R9 tx_valid with data", {31'b0, tx_valid}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      tx_take(b, v);
      check("R9 tx byte valid", {31'b0, v}, 32'h1);
      check("R9 tx byte order", {24'b0, b}, 32'h11 * (i + 1));
    end
    check("R9 tx drained", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_tx_full;
    logic [7:0] b; logic v;
    for (int w = 0; w < 8; w++)
      wr(6'h10, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
    idle(1);
    rd_chk("R5 full tx keeps sticky room", 6'h04, 32'h0020_0100);
    wr(6'h08, 32'h0000_0100);
    wr(6'h04, 32'h0000_0100);
    rd_chk("R6 room cleared when full", 6'h04, 32'h0020_0000);
    check("R8 irq low with flag clear", {31'b0, irq}, 32'h0);
    wr(6'h10, 32'hDEAD_BEEF);
    rd_chk("R11 tx push into full dropped", 6'h04, 32'h0020_0000);
    for (int i = 0; i < 32; i++) begin
      tx_take(b, v);
      if (v !== 1'b1 || b !== 8'(i)) check("R11 tx full drain byte", {23'b0, v, b}, {23'b0, 1'b1, 8'(i)});
    end
    checks++;
    check("R11 tx empty after 32", {31'b0, tx_valid}, 32'h0);
    idle(1);
    check("R8 irq with room and mask", {31'b0, irq}, 32'h1);
    wr(6'h04, 32'h0000_0100);
    rd_chk("R6 set wins over clear", 6'h04, 32'h0000_0100);
    check("R6 irq stays high", {31'b0, irq}, 32'h1);
    wr(6'h08, 32'h0);
  endtask

  task automatic t_rx;
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3);
    rd_chk("R4 count 3 not above threshold", 6'h04, 32'h0300_0100);
    rx_push(8'hA4);
    rd_chk("R4 count 4 sets has-data", 6'h04, 32'h0400_0300);
    check("R8 irq low with mask 0", {31'b0, irq}, 32'h0);
    wr(6'h08, 32'h0000_0200);
    check("R8 irq high on rx mask", {31'b0, irq}, 32'h1);
    wr(6'h04, 32'h0000_0200);
    rd_chk("R6 has-data survives clear", 6'h04, 32'h0400_0300);
    wr(6'h04, 32'h3F3F_0000);
    rd_chk("R7 counts ignore writes", 6'h04, 32'h0400_0300);
    rd_chk("R10 rx word of 4", 6'h14, 32'hA1A2_A3A4);
    rd_chk("R4 flag sticky after drain", 6'h04, 32'h0000_0300);
    wr(6'h04, 32'h0000_0200);
    rd_chk("R6 has-data cleared", 6'h04, 32'h0000_0100);
    check("R8 irq low after clear", {31'b0, irq}, 32'h0);
    rx_push(8'hB1); rx_push(8'hB2);
    rd_chk("R10 partial word zero fill", 6'h14, 32'hB1B2_0000);
    rd_chk("R10 empty read zero", 6'h14, 32'h0);
    wr(6'h08, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    for (int i = 1; i <= 5; i++) rx_push(8'hC0 + 8'(i));
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hC6;
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 6'h14;
    @(negedge clk);
    rx_valid = 1'b0; bus_en = 1'b0;
    d = bus_rdata;
    check("R12 popped word in collision", d, 32'hC1C2_C3C4);
    idle(1);
    rd_chk("R12 count after collision", 6'h04, 32'h0200_0300);
    rd_chk("R12 order after collision", 6'h14, 32'hC5C6_0000);
    wr(6'h04, 32'h0000_0200);
    rd_chk("R12 clean after collision", 6'h04, 32'h0000_0100);
  endtask

  task automatic t_rx_full;
    for (int i = 0; i < 32; i++) rx_push(8'(i));
    check("R11 rx_ready low when full", {31'b0, rx_ready}, 32'h0);
    rx_push(8'hEE);
    rd_chk("R11 rx full count", 6'h04, 32'h2000_0300);
    for (int w = 0; w < 8; w++)
      rd_chk("R11 rx full drain", 6'h14, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
    check("R11 rx_ready back", {31'b0, rx_ready}, 32'h1);
    wr(6'h04, 32'hFFFF_FFFF);
    rd_chk("R6 all-ones clear", 6'h04, 32'h0000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_tx_basic();
    t_tx_full();
    t_rx();
    t_collide();
    t_rx_full();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule